// File: doc/BRIEF.md
# Writeback Pixel Format Packer

The packer sits on the memory-write side of a display writeback path. It takes a stream of pixels, each carrying four 8-bit channels (red, green, blue, alpha), and turns them into a stream of 32-bit memory words with per-byte strobes. A 4-bit format code selects a 16-bit, 24-bit or 32-bit layout and the channel order within it. Because the layouts are packed densely, pixels can straddle word boundaries: two 16-bit pixels share one word, and 24-bit pixels spill across words.

Configuration inputs control alpha handling and byte masking. The alpha channel can be written as it arrives, written inverted, or replaced by a constant fill. A 4-bit byte mask gates the write strobe of each byte lane in every word. A frame ends when the pixel marked last is accepted. Any bytes still held at that point leave in a final word whose strobes cover only the bytes that hold data. Both streams use valid/ready handshakes, and a full output word holds the input stream until the word is taken.

Top module: `wb_pixel_packer`

## Requirements
- R1: After reset `wordValid` and `fmtError` are 0 and `pixReady` is 1 while `wordReady` is 1.
- R2: Codes 12, 13, 14 and 15 give one 32-bit word per pixel. Naming channels from byte 3 down to byte 0, the orders are A,B,G,R / A,R,G,B / B,G,R,A / R,G,B,A.
- R3: Codes 0 to 3 give 16-bit pixels in the same four channel orders as R2, with each channel cut to its upper 4 bits. Two pixels fill one word, and the earlier pixel occupies bits 15:0.
- R4: Code 6 packs blue[7:3], green[7:2], red[7:3] from bit 15 down to bit 0. Code 7 uses the same layout with red and blue swapped. Pixels pack two per word as in R3.
- R5: Code 8 gives 3 bytes per pixel with blue, green, red from the high byte to the low byte. Code 9 swaps red and blue. Bytes form one continuous little-endian stream, so the first byte of the stream lands in bits 7:0 of the first word and pixels cross word boundaries.
- R6: With `cfgAlphaStore`=1, alpha is written as it arrives, or bitwise inverted when `cfgAlphaInvert`=1. With `cfgAlphaStore`=0, every alpha bit equals the inverse of `cfgAlphaInvert`.
- R7: `wordStrobe` bit i is the AND of `cfgByteMask` bit i and "lane i holds pixel data". A word that is not the last word of a frame therefore has strobe equal to `cfgByteMask`.
- R8: At the end of a frame, bytes left over go out in a final word with `wordLast`=1. Its strobes cover only the low lanes that hold data (ANDed with the mask), and its unused bytes are zero. If the last pixel both completes a word and leaves a remainder, the complete word goes out first, then the remainder word, and no input is accepted in between.
- R9: Codes 4, 5, 10 and 11 are invalid. A pixel with an invalid code is accepted and produces no output bytes, and `fmtError` is 1 in the cycle after acceptance. For valid codes `fmtError` is 0.
- R10: While `wordValid`=1 and `wordReady`=0, `wordData`, `wordStrobe` and `wordLast` hold steady. No word is lost or repeated under any pattern of `wordReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Input pixel present |
| pixReady | output | 1 | Packer accepts the pixel this cycle |
| pixRed | input | 8 | Red channel |
| pixGreen | input | 8 | Green channel |
| pixBlue | input | 8 | Blue channel |
| pixAlpha | input | 8 | Alpha channel |
| pixLast | input | 1 | Pixel is the final one of the frame |
| cfgFormat | input | 4 | Output layout code |
| cfgAlphaStore | input | 1 | 1: write the alpha channel; 0: fill alpha with a constant |
| cfgAlphaInvert | input | 1 | Inverts stored alpha, or selects the fill value |
| cfgByteMask | input | 4 | Per-lane write enable for each word |
| wordValid | output | 1 | Output word present |
| wordReady | input | 1 | Sink takes the word this cycle |
| wordData | output | 32 | Packed little-endian word |
| wordStrobe | output | 4 | Byte write strobes |
| wordLast | output | 1 | Final word of the frame |
| fmtError | output | 1 | Pulse: a pixel with an invalid code was accepted |

## Verification
Two functions can collide in one cycle. The first is the end-of-frame overflow, where the last pixel both completes a word and leaves a remainder that needs a flush word. The second is output backpressure, which must hold that word steady while the flush waits. Seven-pixel 24-bit frames are sent while `wordReady` follows a repeating stall pattern, and a monitor compares every transferred word against a queue of words built independently from the byte stream. Any change in a stalled word, any change in word order, any strobe or last-flag mismatch, or any unexpected extra word is reported.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int CHAN_W  = 8;
  localparam int LANES   = 4;
  localparam int CODE_W  = 4;
  localparam int WORD_W  = CHAN_W * LANES;
  localparam int CNT_W   = $clog2(LANES);
  localparam int TOT_W   = CNT_W + 1;
  localparam int TAIL_N  = LANES - 1;
  localparam int TAIL_W  = TAIL_N * CHAN_W;
  localparam int MERGE_N = LANES + TAIL_N;
  localparam int MERGE_W = MERGE_N * CHAN_W;
  localparam int NIB_W   = 4;
  localparam int RB_W    = 5;
  localparam int G_W     = 6;

  typedef logic [CHAN_W-1:0] chan_t;

  typedef enum logic [1:0] {
    FMT_BAD = 2'd0,
    FMT_16  = 2'd1,
    FMT_24  = 2'd2,
    FMT_32  = 2'd3
  } fmt_class_e;

  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic             takePix;
    logic             useHigh;
    logic             emitWord;
    logic             flushTail;
    logic [CNT_W-1:0] cntOld;
  } ctrl_t;

  function automatic fmt_class_e classify(input logic [CODE_W-1:0] code);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd7: classify = FMT_16;
      4'd8, 4'd9:                         classify = FMT_24;
      4'd12, 4'd13, 4'd14, 4'd15:         classify = FMT_32;
      default:                            classify = FMT_BAD;
    endcase
  endfunction

  function automatic logic [TOT_W-1:0] bytesOf(input fmt_class_e c);
    case (c)
      FMT_16:  bytesOf = TOT_W'(2);
      FMT_24:  bytesOf = TOT_W'(3);
      FMT_32:  bytesOf = TOT_W'(4);
      default: bytesOf = '0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] laneMask(input logic [TOT_W-1:0] n);
    for (int i = 0; i < LANES; i++) laneMask[i] = (i < int'(n));
  endfunction
endpackage

// File: rtl/wpk_pixel_fmt.sv
module wpk_pixel_fmt
  import wpk_pkg::*;
(
  input  chan_t              red,
  input  chan_t              green,
  input  chan_t              blue,
  input  chan_t              alpha,
  input  logic [CODE_W-1:0]  code,
  input  logic               alphaStore,
  input  logic               alphaInvert,
  output logic [WORD_W-1:0]  pixWord,
  output logic [TOT_W-1:0]   nBytes
);
  fmt_class_e fmtClass;
  chan_t alphaEff;
  chan_t c3, c2, c1, c0;
  chan_t hiCh, loCh;

  assign fmtClass = classify(code);
  assign nBytes   = bytesOf(fmtClass);

  always_comb begin
    if (alphaStore) alphaEff = alphaInvert ? ~alpha : alpha;
    else            alphaEff = {CHAN_W{~alphaInvert}};
  end

  // four-channel order, high byte first
  always_comb begin
    case (code[1:0])
      2'd0:    begin c3 = alphaEff; c2 = blue;  c1 = green; c0 = red;      end
      2'd1:    begin c3 = alphaEff; c2 = red;   c1 = green; c0 = blue;     end
      2'd2:    begin c3 = blue;     c2 = green; c1 = red;   c0 = alphaEff; end
      default: begin c3 = red;      c2 = green; c1 = blue;  c0 = alphaEff; end
    endcase
  end

  // three-channel order: bit 0 clear puts blue high
  assign hiCh = code[0] ? red  : blue;
  assign loCh = code[0] ? blue : red;

  always_comb begin
    case (fmtClass)
      FMT_32: pixWord = {c3, c2, c1, c0};
      FMT_24: pixWord = WORD_W'({hiCh, green, loCh});
      FMT_16: begin
        if (code[2])
          pixWord = WORD_W'({hiCh[CHAN_W-1 -: RB_W], green[CHAN_W-1 -: G_W],
                             loCh[CHAN_W-1 -: RB_W]});
        else
          pixWord = WORD_W'({c3[CHAN_W-1 -: NIB_W], c2[CHAN_W-1 -: NIB_W],
                             c1[CHAN_W-1 -: NIB_W], c0[CHAN_W-1 -: NIB_W]});
      end
      default: pixWord = '0;
    endcase
  end
endmodule

// File: rtl/wpk_datapath.sv
module wpk_datapath
  import wpk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctl,
  input  chan_t              pixRed,
  input  chan_t              pixGreen,
  input  chan_t              pixBlue,
  input  chan_t              pixAlpha,
  input  logic [CODE_W-1:0]  cfgFormat,
  input  logic               cfgAlphaStore,
  input  logic               cfgAlphaInvert,
  output logic [TOT_W-1:0]   nBytes,
  output logic [WORD_W-1:0]  wordData
);
  logic [WORD_W-1:0]  pixWord;
  logic [TAIL_W-1:0]  tailQ, tailMasked, tailNext;
  logic [MERGE_W-1:0] mergedVec;

  wpk_pixel_fmt fmt_i (
    .red        (pixRed),
    .green      (pixGreen),
    .blue       (pixBlue),
    .alpha      (pixAlpha),
    .code       (cfgFormat),
    .alphaStore (cfgAlphaStore),
    .alphaInvert(cfgAlphaInvert),
    .pixWord    (pixWord),
    .nBytes     (nBytes)
  );

  // keep only the tail bytes that hold data
  always_comb begin
    for (int i = 0; i < TAIL_N; i++)
      tailMasked[i*CHAN_W +: CHAN_W] =
        (i < int'(ctl.cntOld)) ? tailQ[i*CHAN_W +: CHAN_W] : '0;
  end

  // older bytes sit low, the new pixel goes right above them
  assign mergedVec = (MERGE_W'(pixWord) << (int'(ctl.cntOld) * CHAN_W))
                   | MERGE_W'(tailMasked);
  assign tailNext  = ctl.useHigh ? mergedVec[WORD_W +: TAIL_W] : mergedVec[TAIL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tailQ    <= '0;
      wordData <= '0;
    end else begin
      if (ctl.takePix) tailQ <= tailNext;
      if (ctl.emitWord)       wordData <= mergedVec[WORD_W-1:0];
      else if (ctl.flushTail) wordData <= WORD_W'(tailMasked);
    end
  end

  // R8: a word is loaded from one source only
  p_one_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.emitWord, ctl.flushTail}));
endmodule

// File: rtl/wpk_ctrl.sv
module wpk_ctrl
  import wpk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic              pixLast,
  output logic              pixReady,
  input  logic [TOT_W-1:0]  nBytes,
  input  logic [LANES-1:0]  cfgByteMask,
  input  logic              wordReady,
  output logic              wordValid,
  output logic [LANES-1:0]  wordStrobe,
  output logic              wordLast,
  output logic              fmtError,
  output ctrl_t             ctl
);
  typedef enum logic {ST_RUN, ST_FLUSH} st_e;

  st_e              state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             validNext, lastNext;
  logic [LANES-1:0] strbNext;
  logic             slotFree, fire, isBad;
  logic [TOT_W-1:0] total;

  assign slotFree = !wordValid || wordReady;
  assign pixReady = (state == ST_RUN) && slotFree;
  assign fire     = pixValid && pixReady;
  assign isBad    = (nBytes == '0);
  assign total    = TOT_W'(cnt) + nBytes;

  always_comb begin
    stateNext  = state;
    cntNext    = cnt;
    validNext  = wordValid && !wordReady;
    strbNext   = wordStrobe;
    lastNext   = wordLast;
    ctl        = '0;
    ctl.cntOld = cnt;
    case (state)
      ST_RUN: begin
        if (fire) begin
          ctl.takePix = 1'b1;
          if (total >= TOT_W'(LANES)) begin
            ctl.useHigh  = 1'b1;
            ctl.emitWord = 1'b1;
            validNext    = 1'b1;
            strbNext     = cfgByteMask;
            cntNext      = CNT_W'(total - TOT_W'(LANES));
            lastNext     = pixLast && (total == TOT_W'(LANES));
            if (pixLast && (total != TOT_W'(LANES))) stateNext = ST_FLUSH;
          end else if (pixLast) begin
            cntNext = '0;
            if (total != '0) begin
              ctl.emitWord = 1'b1;
              validNext    = 1'b1;
              strbNext     = laneMask(total) & cfgByteMask;
              lastNext     = 1'b1;
            end
          end else begin
            cntNext = CNT_W'(total);
          end
        end
      end
      default: begin
        if (slotFree) begin
          ctl.flushTail = 1'b1;
          validNext     = 1'b1;
          strbNext      = laneMask(TOT_W'(cnt)) & cfgByteMask;
          lastNext      = 1'b1;
          cntNext       = '0;
          stateNext     = ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RUN;
      cnt        <= '0;
      wordValid  <= 1'b0;
      wordStrobe <= '0;
      wordLast   <= 1'b0;
      fmtError   <= 1'b0;
    end else begin
      state      <= stateNext;
      cnt        <= cntNext;
      wordValid  <= validNext;
      wordStrobe <= strbNext;
      wordLast   <= lastNext;
      fmtError   <= fire && isBad;
    end
  end

  // R7: words before the last of a frame carry the full mask
  p_full_unless_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordLast) |-> (wordStrobe == cfgByteMask));

  // R9: an invalid pixel mid-frame leaves the output empty
  p_bad_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixReady && isBad && !pixLast) |=> !wordValid);

  // R9: the error pulse follows an accepted pixel
  p_err_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    fmtError |-> $past(pixValid && pixReady));

  // R8: an overflowing last pixel blocks input for the flush
  p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixReady && pixLast && (total > TOT_W'(LANES))) |=> !pixReady);
endmodule

// File: rtl/wb_pixel_packer.sv
module wb_pixel_packer
  import wpk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixValid,
  output logic        pixReady,
  input  logic [7:0]  pixRed,
  input  logic [7:0]  pixGreen,
  input  logic [7:0]  pixBlue,
  input  logic [7:0]  pixAlpha,
  input  logic        pixLast,
  input  logic [3:0]  cfgFormat,
  input  logic        cfgAlphaStore,
  input  logic        cfgAlphaInvert,
  input  logic [3:0]  cfgByteMask,
  output logic        wordValid,
  input  logic        wordReady,
  output logic [31:0] wordData,
  output logic [3:0]  wordStrobe,
  output logic        wordLast,
  output logic        fmtError
);
  ctrl_t            ctl;
  logic [TOT_W-1:0] nBytes;

  wpk_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .pixValid   (pixValid),
    .pixLast    (pixLast),
    .pixReady   (pixReady),
    .nBytes     (nBytes),
    .cfgByteMask(cfgByteMask),
    .wordReady  (wordReady),
    .wordValid  (wordValid),
    .wordStrobe (wordStrobe),
    .wordLast   (wordLast),
    .fmtError   (fmtError),
    .ctl        (ctl)
  );

  wpk_datapath dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .pixRed        (pixRed),
    .pixGreen      (pixGreen),
    .pixBlue       (pixBlue),
    .pixAlpha      (pixAlpha),
    .cfgFormat     (cfgFormat),
    .cfgAlphaStore (cfgAlphaStore),
    .cfgAlphaInvert(cfgAlphaInvert),
    .nBytes        (nBytes),
    .wordData      (wordData)
  );

  // R10: a stalled word does not change
  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> (wordValid && $stable(wordData)
                                   && $stable(wordStrobe) && $stable(wordLast)));
endmodule

// File: tb/wb_pixel_packer_tb_top.sv
module wb_pixel_packer_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, pixValid, pixReady, pixLast;
  logic [7:0]  pixRed, pixGreen, pixBlue, pixAlpha;
  logic [3:0]  cfgFormat, cfgByteMask;
  logic        cfgAlphaStore, cfgAlphaInvert;
  logic        wordValid, wordReady, wordLast, fmtError;
  logic [31:0] wordData;
  logic [3:0]  wordStrobe;

  wb_pixel_packer dut_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixReady(pixReady),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue), .pixAlpha(pixAlpha),
    .pixLast(pixLast), .cfgFormat(cfgFormat), .cfgAlphaStore(cfgAlphaStore),
    .cfgAlphaInvert(cfgAlphaInvert), .cfgByteMask(cfgByteMask),
    .wordValid(wordValid), .wordReady(wordReady), .wordData(wordData),
    .wordStrobe(wordStrobe), .wordLast(wordLast), .fmtError(fmtError)
  );

  typedef struct {
    logic [31:0] d;
    logic [3:0]  s;
    logic        l;
    string       tag;
  } exp_t;

  exp_t       expQ[$];
  logic [7:0] byteQ[$];
  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  bit  stallOn = 1'b0;
  int  cyc = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // independent layout model: returns byte count and little-endian bytes
  function automatic void modelPix(input logic [3:0] code,
      input logic [7:0] r, input logic [7:0] g, input logic [7:0] b, input logic [7:0] a,
      input bit st, input bit inv, output int n, output logic [31:0] w);
    logic [7:0] ae;
    if (st) ae = inv ? ~a : a;
    else    ae = inv ? 8'h00 : 8'hFF;
    n = 0; w = '0;
    case (code)
      4'd0:  begin n = 2; w = {16'h0, ae[7:4], b[7:4], g[7:4], r[7:4]}; end
      4'd1:  begin n = 2; w = {16'h0, ae[7:4], r[7:4], g[7:4], b[7:4]}; end
      4'd2:  begin n = 2; w = {16'h0, b[7:4], g[7:4], r[7:4], ae[7:4]}; end
      4'd3:  begin n = 2; w = {16'h0, r[7:4], g[7:4], b[7:4], ae[7:4]}; end
      4'd6:  begin n = 2; w = {16'h0, b[7:3], g[7:2], r[7:3]}; end
      4'd7:  begin n = 2; w = {16'h0, r[7:3], g[7:2], b[7:3]}; end
      4'd8:  begin n = 3; w = {8'h0, b, g, r}; end
      4'd9:  begin n = 3; w = {8'h0, r, g, b}; end
      4'd12: begin n = 4; w = {ae, b, g, r}; end
      4'd13: begin n = 4; w = {ae, r, g, b}; end
      4'd14: begin n = 4; w = {b, g, r, ae}; end
      4'd15: begin n = 4; w = {r, g, b, ae}; end
      default: begin n = 0; w = '0; end
    endcase
  endfunction

  task automatic pushModel(input int n, input logic [31:0] w, input bit last,
                           input string tag);
    exp_t e;
    for (int i = 0; i < n; i++) byteQ.push_back(w[8*i +: 8]);
    while (byteQ.size() >= 4) begin
      e.d = '0;
      for (int i = 0; i < 4; i++) e.d[8*i +: 8] = byteQ.pop_front();
      e.s = cfgByteMask;
      e.l = last && (byteQ.size() == 0);
      e.tag = tag;
      expQ.push_back(e);
    end
    if (last && byteQ.size() > 0) begin
      e.d = '0;
      e.s = '0;
      for (int i = 0; byteQ.size() > 0; i++) begin
        e.d[8*i +: 8] = byteQ.pop_front();
        e.s[i] = cfgByteMask[i];
      end
      e.l = 1'b1;
      e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic sendPix(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         input logic [7:0] a, input bit last, input string tag);
    bit got;
    int n;
    logic [31:0] w;
    @(negedge clk);
    pixValid = 1'b1; pixRed = r; pixGreen = g; pixBlue = b; pixAlpha = a; pixLast = last;
    got = 1'b0;
    while (!got) begin
      #4;
      got = pixReady;
      @(posedge clk);
      if (!got) @(negedge clk);
    end
    modelPix(cfgFormat, r, g, b, a, cfgAlphaStore, cfgAlphaInvert, n, w);
    pushModel(n, w, last, tag);
    #8;
    check(fmtError == (n == 0), (n == 0) ? "R9" : tag, "fmtError after accept",
          64'(fmtError), 64'(n == 0));
  endtask

  task automatic sendFrame(input logic [3:0] code, input int count, input bit st,
                           input bit inv, input logic [3:0] mask, input string tag);
    @(negedge clk);
    cfgFormat = code; cfgAlphaStore = st; cfgAlphaInvert = inv; cfgByteMask = mask;
    for (int i = 0; i < count; i++)
      sendPix(8'(8'h1D * i + 8'h93), 8'(8'h37 * i + 8'h4C), 8'(8'h59 * i + 8'hE6),
              8'(8'h6B * i + 8'h25), i == count - 1, tag);
    @(negedge clk);
    pixValid = 1'b0; pixLast = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // output ready pattern
  always @(negedge clk) begin
    cyc++;
    wordReady = stallOn ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic [31:0] prevD;
  logic [3:0]  prevS;
  logic        prevL;
  bit          prevStall = 1'b0;
  always begin
    exp_t e;
    @(posedge clk);
    #16;
    if (rstN) begin
      if (prevStall)
        check(wordValid && wordData == prevD && wordStrobe == prevS && wordLast == prevL,
              "R10", "stalled word changed", {27'h0, wordValid, wordStrobe, wordData},
              {27'h1, prevS, prevD});
      if (wordValid && wordReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "unexpected word", 64'(wordData), 64'h0);
        end else begin
          e = expQ.pop_front();
          check(wordData == e.d, e.tag, "data", 64'(wordData), 64'(e.d));
          check(wordStrobe == e.s, (e.s != 4'hF) ? "R7" : e.tag, "strobe",
                64'(wordStrobe), 64'(e.s));
          check(wordLast == e.l, e.l ? "R8" : e.tag, "last", 64'(wordLast), 64'(e.l));
        end
      end
      prevStall = wordValid && !wordReady;
      prevD = wordData; prevS = wordStrobe; prevL = wordLast;
    end else begin
      prevStall = 1'b0;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pixValid = 1'b0; pixLast = 1'b0;
    pixRed = '0; pixGreen = '0; pixBlue = '0; pixAlpha = '0;
    cfgFormat = 4'd13; cfgAlphaStore = 1'b1; cfgAlphaInvert = 1'b0; cfgByteMask = 4'hF;
    wordReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #4;
    check(wordValid == 1'b0, "R1", "wordValid after reset", 64'(wordValid), 64'h0);
    check(fmtError == 1'b0, "R1", "fmtError after reset", 64'(fmtError), 64'h0);
    check(pixReady == 1'b1, "R1", "pixReady after reset", 64'(pixReady), 64'h1);

    // R2: 32-bit orders
    sendFrame(4'd13, 3, 1'b1, 1'b0, 4'hF, "R2");
    sendFrame(4'd12, 2, 1'b1, 1'b0, 4'hF, "R2");
    sendFrame(4'd14, 2, 1'b1, 1'b0, 4'hF, "R2");
    sendFrame(4'd15, 2, 1'b1, 1'b0, 4'hF, "R2");
    // R3: 4444 orders, two per word
    for (int c = 0; c < 4; c++) sendFrame(4'(c), 4, 1'b1, 1'b0, 4'hF, "R3");
    sendFrame(4'd1, 3, 1'b1, 1'b0, 4'hF, "R3");
    // R4: 565
    sendFrame(4'd6, 2, 1'b1, 1'b0, 4'hF, "R4");
    sendFrame(4'd7, 4, 1'b1, 1'b0, 4'hF, "R4");
    // R5: 24-bit across words
    sendFrame(4'd9, 4, 1'b1, 1'b0, 4'hF, "R5");
    sendFrame(4'd8, 5, 1'b1, 1'b0, 4'hF, "R5");
    // R8: overflow on the last pixel needs a flush word
    sendFrame(4'd9, 7, 1'b1, 1'b0, 4'hF, "R8");
    // R6: alpha handling
    sendFrame(4'd15, 2, 1'b0, 1'b0, 4'hF, "R6");
    sendFrame(4'd15, 2, 1'b0, 1'b1, 4'hF, "R6");
    sendFrame(4'd13, 2, 1'b1, 1'b1, 4'hF, "R6");
    sendFrame(4'd2, 2, 1'b0, 1'b1, 4'hF, "R6");
    // R7: byte mask
    sendFrame(4'd13, 2, 1'b1, 1'b0, 4'b0101, "R7");
    sendFrame(4'd9, 3, 1'b1, 1'b0, 4'b1010, "R7");
    // R9: invalid codes
    sendFrame(4'd5, 2, 1'b1, 1'b0, 4'hF, "R9");
    sendFrame(4'd10, 1, 1'b1, 1'b0, 4'hF, "R9");
    check(expQ.size() == 0, "R9", "words pending after invalid frames", 64'(expQ.size()), 64'h0);
    sendFrame(4'd12, 1, 1'b1, 1'b0, 4'hF, "R9");
    // R10: backpressure with flush and 16-bit pairing
    stallOn = 1'b1;
    sendFrame(4'd9, 7, 1'b1, 1'b0, 4'hF, "R10");
    sendFrame(4'd0, 5, 1'b1, 1'b0, 4'hF, "R10");
    sendFrame(4'd14, 3, 1'b0, 1'b0, 4'hF, "R10");
    stallOn = 1'b0;
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R10", "words missing at end", 64'(expQ.size()), 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule